// File: doc/BRIEF.md
# Payload Power-On Timeout Supervisor

This block starts a board's payload power and watches whether it comes up. When the board is asked to go active, the block raises a power-enable output and then waits for a power-good input from the payload supply. If power-good shows up inside a fixed window, the payload counts as powered. If the window runs out first, the block marks a "unit did not respond to power-on" condition in its sensor status vector. It then hands exactly one event record to the management controller.

The sensor status vector holds one bit per sensor-specific offset. Offset 0 means the payload is off. This bit is status only and never causes an event. Offset 5 means the power-on attempt timed out, and setting it produces the event. The event record gives the power-unit sensor type and the offset code. It is offered on a valid/ready handshake and stays unchanged until the controller accepts it. The window length is set in clock ticks per second times a number of seconds, so a bench can use a short window and silicon can use the full two seconds.

Top module: `pwr_supervisor`

## Requirements
- R1: Out of reset, `pwr_en` is 0, `sensor_status` is 8'h01 (bit 0 set: payload off) and `evt_valid` is 0.
- R2: In idle, an activate request with no deactivate request raises `pwr_en` after the next clock edge and starts a fresh timeout window of W = TICKS_PER_SEC*WINDOW_SEC cycles.
- R3: Power-good is checked on each of the W clock edges after the enable edge. If it is seen on any of them, including the W-th, the payload counts as powered. Bit 0 of `sensor_status` clears, `pwr_en` stays high and no event is produced.
- R4: If power-good is low on all W edges, then at the W-th edge bit 5 of `sensor_status` sets (status becomes 8'h21) and `evt_valid` rises. Neither happens earlier.
- R5: While `evt_valid` is high, `evt_sensor_type` is 8'h01 and `evt_data1` is 8'h05 (offset code in bits 3:0, bits 7:4 zero). Both hold stable until `evt_ready` is seen.
- R6: Each timeout produces exactly one event. `evt_valid` falls after the edge where `evt_ready` is high and does not rise again during that failure.
- R7: Power-good arriving after the timeout, or a new activate request, leaves bit 5 set. Only a deactivate request clears it.
- R8: A deactivate request takes priority over everything else. After the next edge `pwr_en` is 0 and `sensor_status` is 8'h01, whatever the state was and even if an activate request came in the same cycle.
- R9: Setting the payload-off bit (bit 0) never produces an event.
- R10: Activate requests while power is already enabled are ignored and do not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activate_req | input | 1 | Request to enter the active state and power the payload |
| deactivate_req | input | 1 | Request to remove payload power and return to idle |
| power_good | input | 1 | Payload supply reports good output |
| evt_ready | input | 1 | Management controller accepts the offered event |
| pwr_en | output | 1 | Payload power enable |
| sensor_status | output | 8 | Bit n set means sensor offset n is asserted |
| evt_valid | output | 1 | An event record is offered |
| evt_sensor_type | output | 8 | Sensor type code of the offered event |
| evt_data1 | output | 8 | Event data byte 1; offset code in bits 3:0 |

## Verification
A wrong sequencer state shows up at once on `pwr_en` or in `sensor_status` bit 0, no later than one edge after the stimulus. A window counter that is off by one shows up only at the end of the window, when bit 5 and `evt_valid` rise one edge early or one edge late. The bench therefore samples at the W-1-th and W-th edge, and it places power-good on exactly the W-th edge. An event port that loses its record, or sends it twice, is seen at the handshake. The scoreboard then finds a popped record with no matching expected record, or an expected record left over at the end.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WAIT,
        PS_ON,
        PS_FAIL
    } pwr_state_e;

    localparam int unsigned STATUS_W = 8;

    localparam logic [7:0] SENSOR_TYPE_PWR_UNIT = 8'h01;
    localparam logic [3:0] OFS_PAYLOAD_OFF      = 4'h0;
    localparam logic [3:0] OFS_NO_RESPONSE      = 4'h5;

    typedef struct packed {
        logic [7:0] sensor_type;
        logic [7:0] data1;
    } sensor_evt_t;

    function automatic logic [STATUS_W-1:0] ofs_mask(input logic [3:0] ofs);
        logic [STATUS_W-1:0] m;
        m = '0;
        m[ofs[2:0]] = 1'b1;
        return m;
    endfunction

    function automatic sensor_evt_t make_evt(input logic [3:0] ofs);
        sensor_evt_t e;
        e.sensor_type = SENSOR_TYPE_PWR_UNIT;
        e.data1       = {4'h0, ofs};
        return e;
    endfunction

endpackage

// File: rtl/pwr_window_timer.sv
module pwr_window_timer #(
    parameter int unsigned WINDOW_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last_tick
);
    localparam int unsigned CNT_W = $clog2(WINDOW_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_CNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_tick = run && (cnt == LAST_CNT);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_sup_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                activate_req,
    input  logic                deactivate_req,
    input  logic                power_good,
    input  logic                last_tick,
    output pwr_state_e          state,
    output logic                timeout_fire,
    output logic [STATUS_W-1:0] status
);
    pwr_state_e state_nxt;

    always_comb begin
        state_nxt    = state;
        timeout_fire = 1'b0;
        if (deactivate_req) begin
            state_nxt = PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE: if (activate_req) state_nxt = PS_WAIT;
                PS_WAIT: begin
                    if (power_good) begin
                        state_nxt = PS_ON;
                    end else if (last_tick) begin
                        state_nxt    = PS_FAIL;
                        timeout_fire = 1'b1;
                    end
                end
                default: state_nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_IDLE;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || deactivate_req) begin
            status <= ofs_mask(OFS_PAYLOAD_OFF);
        end else if (state == PS_WAIT && power_good) begin
            status <= status & ~ofs_mask(OFS_PAYLOAD_OFF);
        end else if (timeout_fire) begin
            status <= status | ofs_mask(OFS_NO_RESPONSE);
        end
    end

endmodule

// File: rtl/pwr_event_port.sv
module pwr_event_port
    import pwr_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [3:0] ofs,
    input  logic       ready,
    output logic       valid,
    output logic [7:0] sensor_type,
    output logic [7:0] data1
);
    sensor_evt_t rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rec   <= '0;
        end else if (fire && !valid) begin
            valid <= 1'b1;
            rec   <= make_evt(ofs);
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    assign sensor_type = valid ? rec.sensor_type : 8'h00;
    assign data1       = valid ? rec.data1       : 8'h00;

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned WINDOW_SEC    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       activate_req,
    input  logic       deactivate_req,
    input  logic       power_good,
    input  logic       evt_ready,
    output logic       pwr_en,
    output logic [7:0] sensor_status,
    output logic       evt_valid,
    output logic [7:0] evt_sensor_type,
    output logic [7:0] evt_data1
);
    localparam int unsigned WINDOW_TICKS = TICKS_PER_SEC * WINDOW_SEC;

    pwr_state_e          state;
    logic                last_tick;
    logic                timeout_fire;
    logic [STATUS_W-1:0] status;

    pwr_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (state == PS_WAIT),
        .last_tick (last_tick)
    );

    pwr_seq_fsm i_fsm (
        .clk            (clk),
        .rst            (rst),
        .activate_req   (activate_req),
        .deactivate_req (deactivate_req),
        .power_good     (power_good),
        .last_tick      (last_tick),
        .state          (state),
        .timeout_fire   (timeout_fire),
        .status         (status)
    );

    pwr_event_port i_evt (
        .clk         (clk),
        .rst         (rst),
        .fire        (timeout_fire),
        .ofs         (OFS_NO_RESPONSE),
        .ready       (evt_ready),
        .valid       (evt_valid),
        .sensor_type (evt_sensor_type),
        .data1       (evt_data1)
    );

    assign pwr_en        = (state != PS_IDLE);
    assign sensor_status = status;

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned WINDOW_SEC    = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       activate_req,
    input logic       deactivate_req,
    input logic       power_good,
    input logic       evt_ready,
    input logic       pwr_en,
    input logic [7:0] sensor_status,
    input logic       evt_valid,
    input logic [7:0] evt_sensor_type,
    input logic [7:0] evt_data1
);
    localparam int unsigned WINDOW_TICKS = TICKS_PER_SEC * WINDOW_SEC;

    logic [31:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            win_cnt <= '0;
        end else if (sensor_status[0] && !sensor_status[5]) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwr_en && sensor_status == 8'h01 && !evt_valid));

    assert_window_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_status[5]) |-> (win_cnt == WINDOW_TICKS && evt_valid));

    assert_evt_code_R5: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_sensor_type == 8'h01 && evt_data1 == 8'h05));

    assert_evt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_data1) && $stable(evt_sensor_type)));

    assert_evt_once_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_ready) |=> !evt_valid);

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (sensor_status[5] && !deactivate_req) |=> sensor_status[5]);

    assert_deact_R8: assert property (@(posedge clk) disable iff (rst)
        deactivate_req |=> (!pwr_en && sensor_status == 8'h01));

    assert_off_no_evt_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_status[0]) |-> !$rose(evt_valid));

endmodule

bind pwr_supervisor pwr_supervisor_chk #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .WINDOW_SEC    (WINDOW_SEC)
) i_chk (.*);

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;

    localparam int TPS  = 8;
    localparam int WSEC = 2;
    localparam int W    = TPS * WSEC;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       activate_req = 1'b0;
    logic       deactivate_req = 1'b0;
    logic       power_good = 1'b0;
    logic       evt_ready = 1'b0;
    logic       pwr_en;
    logic [7:0] sensor_status;
    logic       evt_valid;
    logic [7:0] evt_sensor_type;
    logic [7:0] evt_data1;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];

    always #(CLK_P / 2) clk = ~clk;

    pwr_supervisor #(.TICKS_PER_SEC(TPS), .WINDOW_SEC(WSEC)) i_pwr_supervisor (
        .clk (clk), .rst (rst),
        .activate_req (activate_req), .deactivate_req (deactivate_req),
        .power_good (power_good), .evt_ready (evt_ready),
        .pwr_en (pwr_en), .sensor_status (sensor_status),
        .evt_valid (evt_valid), .evt_sensor_type (evt_sensor_type),
        .evt_data1 (evt_data1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic activate_pulse();
        activate_req = 1'b1; cyc(1); activate_req = 1'b0;
    endtask

    task automatic deactivate_pulse();
        deactivate_req = 1'b1; cyc(1); deactivate_req = 1'b0;
    endtask

    task automatic expect_event();
        exp_q.push_back({8'h01, 8'h05});
    endtask

    // Monitor: pops the scoreboard on each accepted event, checks holding while stalled
    logic        prev_stall = 1'b0;
    logic [15:0] prev_rec   = '0;
    always begin
        @(negedge clk);
        #1;
        if (!rst && evt_valid) begin
            if (prev_stall)
                chk({evt_sensor_type, evt_data1} == prev_rec, "R5 hold",
                    {16'h0, evt_sensor_type, evt_data1}, {16'h0, prev_rec});
            if (evt_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected event", {16'h0, evt_sensor_type, evt_data1}, 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk({evt_sensor_type, evt_data1} == e, "R5 record",
                        {16'h0, evt_sensor_type, evt_data1}, {16'h0, e});
                end
                prev_stall = 1'b0;
            end else begin
                prev_stall = 1'b1;
                prev_rec   = {evt_sensor_type, evt_data1};
            end
        end else begin
            prev_stall = 1'b0;
        end
    end

    initial begin
        #(CLK_P * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(!pwr_en && sensor_status == 8'h01 && !evt_valid, "R1",
            {23'h0, pwr_en, sensor_status}, 32'h01);

        // R2 / R3: success in the middle of the window
        activate_pulse();
        chk(pwr_en && sensor_status == 8'h01, "R2", {23'h0, pwr_en, sensor_status}, 32'h101);
        cyc(2);
        power_good = 1'b1; cyc(1); power_good = 1'b0;
        chk(pwr_en && sensor_status == 8'h00 && !evt_valid, "R3 mid",
            {22'h0, evt_valid, pwr_en, sensor_status}, 32'h100);

        // R8 / R9: deactivate from powered state
        deactivate_pulse();
        chk(!pwr_en && sensor_status == 8'h01 && !evt_valid, "R8 from on",
            {22'h0, evt_valid, pwr_en, sensor_status}, 32'h001);
        cyc(3);
        chk(!evt_valid, "R9", {31'h0, evt_valid}, 32'h0);

        // R3 boundary: power-good on the W-th edge
        activate_pulse();
        cyc(W - 1);
        chk(sensor_status == 8'h01 && !evt_valid, "R4 not early",
            {23'h0, evt_valid, sensor_status}, 32'h01);
        power_good = 1'b1; cyc(1); power_good = 1'b0;
        chk(sensor_status == 8'h00 && !evt_valid && pwr_en, "R3 last tick",
            {22'h0, evt_valid, pwr_en, sensor_status}, 32'h100);
        deactivate_pulse();

        // R4 / R5 / R6 / R7: timeout with stalled consumer
        activate_pulse();
        cyc(W - 1);
        chk(sensor_status == 8'h01 && !evt_valid, "R4 edge W-1",
            {23'h0, evt_valid, sensor_status}, 32'h01);
        expect_event();
        cyc(1);
        chk(sensor_status == 8'h21 && evt_valid && pwr_en, "R4 timeout",
            {22'h0, evt_valid, pwr_en, sensor_status}, 32'h321);
        chk(evt_sensor_type == 8'h01 && evt_data1 == 8'h05, "R5 fields",
            {16'h0, evt_sensor_type, evt_data1}, 32'h0105);
        cyc(4);
        chk(evt_valid, "R5 held while stalled", {31'h0, evt_valid}, 32'h1);
        evt_ready = 1'b1; cyc(1); evt_ready = 1'b0;
        chk(!evt_valid, "R6 drop after accept", {31'h0, evt_valid}, 32'h0);
        evt_ready = 1'b1;
        power_good = 1'b1; cyc(3); power_good = 1'b0;
        chk(sensor_status == 8'h21 && !evt_valid, "R7 late power-good",
            {23'h0, evt_valid, sensor_status}, 32'h21);
        activate_pulse();
        cyc(2);
        chk(sensor_status == 8'h21 && !evt_valid, "R7 activate in failure",
            {23'h0, evt_valid, sensor_status}, 32'h21);
        deactivate_pulse();
        chk(!pwr_en && sensor_status == 8'h01, "R8 from failure",
            {23'h0, pwr_en, sensor_status}, 32'h01);

        // R10: repeated activate does not restart the window
        activate_pulse();
        cyc(4);
        activate_pulse();
        cyc(W - 6);
        chk(sensor_status == 8'h01, "R10 edge W-1", {24'h0, sensor_status}, 32'h01);
        expect_event();
        cyc(1);
        chk(sensor_status == 8'h21 && evt_valid, "R10 timeout at W",
            {23'h0, evt_valid, sensor_status}, 32'h121);
        cyc(1);
        chk(!evt_valid, "R6 single event", {31'h0, evt_valid}, 32'h0);
        deactivate_pulse();

        // R8: deactivate wins over simultaneous activate
        activate_req = 1'b1; deactivate_req = 1'b1; cyc(1);
        activate_req = 1'b0; deactivate_req = 1'b0;
        chk(!pwr_en && sensor_status == 8'h01, "R8 priority",
            {23'h0, pwr_en, sensor_status}, 32'h01);

        // R2: deactivate mid-window, then a fresh full window
        activate_pulse();
        cyc(5);
        deactivate_pulse();
        chk(!pwr_en && !evt_valid, "R8 mid-window", {30'h0, evt_valid, pwr_en}, 32'h0);
        activate_pulse();
        cyc(W - 1);
        chk(sensor_status == 8'h01 && !evt_valid, "R2 fresh window",
            {23'h0, evt_valid, sensor_status}, 32'h01);
        power_good = 1'b1; cyc(1); power_good = 1'b0;
        chk(sensor_status == 8'h00, "R3 after restart", {24'h0, sensor_status}, 32'h00);
        deactivate_pulse();
        cyc(3);

        chk(exp_q.size() == 0, "R6 all events delivered", exp_q.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule